// File: doc/BRIEF.md
# Block-Enabled Pipelined Multiply-Accumulate Unit

This block keeps a running sum of products of two unsigned 8-bit operands. It can take one new operand pair every clock. A pair moves through five registered steps. An input register captures it. A multiplier stage compresses the partial products down to two rows. An adder stage resolves those rows into the product. An accumulator stage adds the product to the running sum. An output register then presents the sum.

A small sequencer moves a valid tag down the pipeline one stage per cycle. A stage's registers load only when the tag says valid data is arriving from the stage in front of it. Stages that real data has not yet reached hold their contents. A clear flag that arrives with a valid pair makes that pair's product the new sum, so a fresh sum can start with no bubble.

The parameter `GATED` selects the variant. With `GATED=1` the stage loads follow the sequencer. With `GATED=0` every register loads on every cycle, and the accumulator adds zero when no valid data is present. Both variants produce the same output sequence.

Top module: `bemac_top`

## Requirements
- R1: The product of each valid pair is exact: op_a times op_b, both unsigned, 0 to 65025.
- R2: Each valid pair with clr low adds its product to the running sum.
- R3: A pair sampled with in_valid and clr both high makes the sum equal to its own product, dropping the previous sum.
- R4: The result of a pair sampled at a rising edge is on acc_out, with acc_valid high, from the fifth rising edge (counting the sampling edge as the first) until the next rising edge.
- R5: acc_valid reproduces the pattern of in_valid, gaps included, delayed by the latency of R4. Exactly one result is produced per valid pair.
- R6: While in_valid is low, op_a, op_b and clr have no effect. acc_out keeps its value, and the sum continues unchanged at the next valid pair.
- R7: The `GATED=1` and `GATED=0` variants produce identical acc_out and acc_valid on every cycle after reset.
- R8: While rst is high at a rising edge, acc_out becomes 0 and acc_valid becomes 0. The first sum after reset starts from 0.
- R9: The sum wraps modulo 2^18 with no saturation. Six back-to-back 255 x 255 pairs, the first with clr, give 128006.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on op_a/op_b is valid this cycle |
| clr | input | 1 | With in_valid: start a new sum from this product |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| acc_out | output | 18 | Running sum of products, modulo 2^18 |
| acc_valid | output | 1 | acc_out was just updated by a valid pair |

## Verification
The main function is exercised with several input patterns.

- A single isolated pair checks the exact latency.
- A back-to-back burst exercises the feedback of the running sum.
- Pairs separated by gaps of different lengths, with the operands toggling and clr raised during the gaps, show that idle cycles neither add stray products nor disturb the held sum.
- A clear in the middle of a stream shows that the new sum starts from that pair's product and not from the old sum.
- Repeated 255 x 255 pairs push the sum past 2^18 to check the wrap.

Both variants run side by side on the same stimulus, which separates a fault in the stage loads from a fault in the arithmetic.

// File: rtl/bemac_pkg.sv
package bemac_pkg;
  // number of pipeline stages behind the input register
  localparam int STAGES = 4;

  typedef enum logic [1:0] {
    STG_MUL = 2'd0,
    STG_ADD = 2'd1,
    STG_ACC = 2'd2,
    STG_OUT = 2'd3
  } stage_e;
endpackage

// File: rtl/bemac_ctrl.sv
module bemac_ctrl #(
  parameter bit GATED  = 1'b1,
  parameter int STAGES = bemac_pkg::STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              ld_in,
  output logic [STAGES-1:0] ld_stage,
  output logic [STAGES:0]   stg_tag
);
  // stg_tag[k]: register level k holds data of a valid pair
  always_ff @(posedge clk) begin
    if (rst) stg_tag <= '0;
    else     stg_tag <= {stg_tag[STAGES-1:0], in_valid};
  end

  generate
    if (GATED) begin : g_gated
      assign ld_in    = in_valid;
      assign ld_stage = stg_tag[STAGES-1:0];
    end else begin : g_free
      assign ld_in    = 1'b1;
      assign ld_stage = '1;
    end
  endgenerate
endmodule

// File: rtl/bemac_mul.sv
module bemac_mul #(
  parameter int OPW = 8,
  localparam int PW = 2 * OPW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld,
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  input  logic           clr_in,
  output logic [PW-1:0]  sum_row,
  output logic [PW-1:0]  car_row,
  output logic           clr_q
);
  // Carry-save reduction of the partial-product rows down to two rows.
  function automatic logic [2*PW-1:0] wallace_rows(input logic [OPW-1:0] x,
                                                   input logic [OPW-1:0] y);
    logic [PW-1:0] row [OPW];
    logic [PW-1:0] nxt [OPW];
    logic [PW-1:0] p, q, r;
    int n;
    int m;
    for (int i = 0; i < OPW; i++) row[i] = y[i] ? (PW'(x) << i) : '0;
    n = OPW;
    for (int lvl = 0; lvl < OPW; lvl++) begin
      if (n > 2) begin
        m = 0;
        for (int i = 0; i < OPW; i++) nxt[i] = '0;
        for (int g = 0; g < OPW / 3; g++) begin
          if (3 * g + 2 < n) begin
            p = row[3*g];
            q = row[3*g+1];
            r = row[3*g+2];
            nxt[m]   = p ^ q ^ r;
            nxt[m+1] = ((p & q) | (p & r) | (q & r)) << 1;
            m = m + 2;
          end
        end
        for (int i = 0; i < OPW; i++) begin
          if (i >= 3 * (n / 3) && i < n) begin
            nxt[m] = row[i];
            m = m + 1;
          end
        end
        for (int i = 0; i < OPW; i++) row[i] = nxt[i];
        n = m;
      end
    end
    return {row[1], row[0]};
  endfunction

  logic [2*PW-1:0] rows_d;
  assign rows_d = wallace_rows(a, b);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_row <= '0;
      car_row <= '0;
      clr_q   <= 1'b0;
    end else if (ld) begin
      sum_row <= rows_d[PW-1:0];
      car_row <= rows_d[2*PW-1:PW];
      clr_q   <= clr_in;
    end
  end

  // R6
  mul_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ($stable(sum_row) && $stable(car_row)));
endmodule

// File: rtl/bemac_cpa.sv
module bemac_cpa #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [PW-1:0] sum_row,
  input  logic [PW-1:0] car_row,
  input  logic          clr_in,
  output logic [PW-1:0] prod_q,
  output logic          clr_q
);
  function automatic logic [PW-1:0] cpa_add(input logic [PW-1:0] s,
                                            input logic [PW-1:0] c);
    return s + c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      clr_q  <= 1'b0;
    end else if (ld) begin
      prod_q <= cpa_add(sum_row, car_row);
      clr_q  <= clr_in;
    end
  end
endmodule

// File: rtl/bemac_acc.sv
module bemac_acc #(
  parameter int PW   = 16,
  parameter int ACCW = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_acc,
  input  logic            ld_out,
  input  logic            vld,
  input  logic            clr_in,
  input  logic [PW-1:0]   prod,
  output logic [ACCW-1:0] out_q
);
  function automatic logic [ACCW-1:0] acc_step(input logic [ACCW-1:0] acc,
                                               input logic [PW-1:0]   p,
                                               input logic            restart);
    return (restart ? '0 : acc) + ACCW'(p);
  endfunction

  logic [ACCW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst)         acc_q <= '0;
    else if (ld_acc) acc_q <= vld ? acc_step(acc_q, prod, clr_in) : acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         out_q <= '0;
    else if (ld_out) out_q <= acc_q;
  end

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_acc |=> $stable(acc_q));

  // R2
  out_copy_chk: assert property (@(posedge clk) disable iff (rst)
    ld_out |=> (out_q == $past(acc_q)));
endmodule

// File: rtl/bemac_top.sv
module bemac_top #(
  parameter int OPW   = 8,
  parameter int ACCW  = 18,
  parameter bit GATED = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            clr,
  input  logic [OPW-1:0]  op_a,
  input  logic [OPW-1:0]  op_b,
  output logic [ACCW-1:0] acc_out,
  output logic            acc_valid
);
  import bemac_pkg::*;
  localparam int PW = 2 * OPW;

  logic              ld_in;
  logic [STAGES-1:0] ld_stage;
  logic [STAGES:0]   stg_tag;

  bemac_ctrl #(.GATED(GATED), .STAGES(STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .ld_in(ld_in), .ld_stage(ld_stage), .stg_tag(stg_tag)
  );

  // input register
  logic [OPW-1:0] a_q, b_q;
  logic           clr0_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      clr0_q <= 1'b0;
    end else if (ld_in) begin
      a_q    <= op_a;
      b_q    <= op_b;
      clr0_q <= clr & in_valid;
    end
  end

  logic [PW-1:0] sum_row, car_row, prod_q;
  logic          clr1_q, clr2_q;

  bemac_mul #(.OPW(OPW)) u_mul (
    .clk(clk), .rst(rst), .ld(ld_stage[STG_MUL]),
    .a(a_q), .b(b_q), .clr_in(clr0_q),
    .sum_row(sum_row), .car_row(car_row), .clr_q(clr1_q)
  );

  bemac_cpa #(.PW(PW)) u_cpa (
    .clk(clk), .rst(rst), .ld(ld_stage[STG_ADD]),
    .sum_row(sum_row), .car_row(car_row), .clr_in(clr1_q),
    .prod_q(prod_q), .clr_q(clr2_q)
  );

  bemac_acc #(.PW(PW), .ACCW(ACCW)) u_acc (
    .clk(clk), .rst(rst),
    .ld_acc(ld_stage[STG_ACC]), .ld_out(ld_stage[STG_OUT]),
    .vld(stg_tag[2]), .clr_in(clr2_q), .prod(prod_q),
    .out_q(acc_out)
  );

  assign acc_valid = stg_tag[STAGES];

  // cycles since reset, saturating; keeps $past inside the post-reset window
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 7) since_rst <= since_rst + 3'd1;
  end

  // R1
  product_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3 && stg_tag[2]) |->
      (prod_q == (PW'($past(a_q, 2)) * PW'($past(b_q, 2)))));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5) |-> (acc_valid == $past(in_valid, 5)));
endmodule

// File: tb/bemac_top_tb.sv
module bemac_top_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, in_valid, clr;
  logic [7:0]  op_a, op_b;
  logic [17:0] out_g, out_u;
  logic        vld_g, vld_u;

  bemac_top #(.GATED(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .clr(clr),
    .op_a(op_a), .op_b(op_b), .acc_out(out_g), .acc_valid(vld_g)
  );
  bemac_top #(.GATED(1'b0)) u_ref (
    .clk(clk), .rst(rst), .in_valid(in_valid), .clr(clr),
    .op_a(op_a), .op_b(op_b), .acc_out(out_u), .acc_valid(vld_u)
  );

  int    checks = 0, fails = 0;
  int    model = 0;
  int    exp_val [64];
  string exp_tag [64];
  int    wr = 0, rd = 0;
  int    lock_bad = 0;
  bit    run_mon = 1'b0;

  function automatic int mac_ref(int acc, int a, int b, bit c);
    int t;
    t = a * b;
    if (!c) t = t + acc;
    return t & 32'h3FFFF;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // result monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (run_mon && !rst) begin
      if (out_g !== out_u || vld_g !== vld_u) lock_bad++;
      if (vld_g) begin
        if (rd == wr) check(1'b0, "R5 result with no pending pair", int'(out_g), -1);
        else begin
          check(out_g == 18'(exp_val[rd % 64]), exp_tag[rd % 64],
                int'(out_g), exp_val[rd % 64]);
          rd++;
        end
      end
    end
  end

  task automatic push_op(int a, int b, bit c, string tag);
    @(negedge clk);
    in_valid = 1'b1; op_a = 8'(a); op_b = 8'(b); clr = c;
    model = mac_ref(model, a, b, c);
    exp_val[wr % 64] = model;
    exp_tag[wr % 64] = tag;
    wr++;
  endtask

  task automatic gap(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; op_a = op_a + 8'd37; op_b = op_b ^ 8'h5A; clr = 1'b1;
    end
  endtask

  task automatic drain(string req);
    int w;
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
    w = 0;
    while (rd != wr && w < 20) begin
      @(negedge clk);
      w++;
    end
    @(negedge clk);
    check(rd == wr, req, rd, wr);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; clr = 1'b0; op_a = 8'd9; op_b = 8'd9;
    repeat (3) @(negedge clk);
    check(out_g == 18'd0, "R8 acc_out in reset", int'(out_g), 0);
    check(vld_g == 1'b0, "R8 acc_valid in reset", int'(vld_g), 0);
    rst = 1'b0;
    run_mon = 1'b1;
    model = 0;
  endtask

  task automatic t_latency();
    int cnt;
    push_op(3, 5, 1'b0, "R8 first sum starts at 0");
    cnt = 0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      in_valid = 1'b0;
    end while (!vld_g && cnt < 10);
    check(cnt == 5, "R4 latency in edges", cnt, 5);
    drain("R5 single pair delivered");
  endtask

  task automatic t_product();
    push_op(200, 173, 1'b1, "R1 200x173");
    push_op(0, 255, 1'b1, "R1 0x255");
    push_op(255, 1, 1'b1, "R1 255x1");
    push_op(128, 128, 1'b1, "R1 128x128");
    drain("R5 product pairs delivered");
  endtask

  task automatic t_burst();
    push_op(12, 34, 1'b1, "R2 burst start");
    push_op(56, 78, 1'b0, "R2 burst");
    push_op(90, 11, 1'b0, "R2 burst");
    push_op(1, 1, 1'b0, "R2 burst");
    push_op(250, 3, 1'b0, "R2 burst");
    push_op(17, 19, 1'b0, "R2 burst");
    drain("R5 burst delivered");
    check(out_g == 18'(model), "R2 burst final sum", int'(out_g), model);
  endtask

  task automatic t_gaps();
    logic [17:0] held;
    int          rd0;
    held = out_g;
    rd0  = rd;
    gap(6);
    check(out_g == held, "R6 acc_out held over idle inputs", int'(out_g), int'(held));
    check(rd == rd0 && !vld_g, "R6 no result from idle inputs", rd - rd0, 0);
    push_op(4, 4, 1'b0, "R6 sum continues after idle clr");
    gap(1);
    push_op(5, 6, 1'b0, "R5 after 1-cycle gap");
    gap(2);
    push_op(7, 8, 1'b0, "R5 after 2-cycle gap");
    gap(3);
    push_op(9, 10, 1'b0, "R5 after 3-cycle gap");
    drain("R5 gapped pairs delivered");
  endtask

  task automatic t_clear();
    push_op(100, 100, 1'b0, "R3 before clear");
    push_op(7, 9, 1'b1, "R3 clear loads 63");
    push_op(2, 3, 1'b0, "R3 add after clear");
    drain("R5 clear pairs delivered");
    check(out_g == 18'd69, "R3 sum after clear", int'(out_g), 69);
  endtask

  task automatic t_wrap();
    push_op(255, 255, 1'b1, "R9 wrap");
    for (int i = 0; i < 5; i++) push_op(255, 255, 1'b0, "R9 wrap");
    drain("R5 wrap pairs delivered");
    check(out_g == 18'd128006, "R9 wrapped sum", int'(out_g), 128006);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", rd, wr);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_product();
    t_burst();
    t_gaps();
    t_clear();
    t_wrap();
    check(lock_bad == 0, "R7 gated and free-running variants agree", lock_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule